// File: doc/BRIEF.md
# Compare, Branch and Linkage Unit

This unit holds the condition code of a 24-bit accumulator machine and decides every control transfer that depends on it. Each cycle in which `valid_i` is high, it performs one operation. The operation is chosen by a 4-bit code. The unit can compare the accumulator with an operand, compare two register values, step the index register and compare the result, take one of three conditional jumps, call a subroutine, or return from one. The surrounding core supplies the register values and the decoded operand. It also supplies the target address and the sequential next-PC. Register file writes and instruction fetch stay outside the unit. The unit reports them through write enables and a PC output.

The condition code is a three-state machine with the states `CC_LT` (00), `CC_EQ` (01) and `CC_GT` (10). Reset enters `CC_EQ`. A compare-type operation (codes 1 to 4) moves the machine to the state given by the signed comparison of its two operands. This transition can go from any state to any state. Every other cycle takes the self-loop, so the code is sticky. All results are registered and appear one clock after the edge that samples the operation.

Top module: `cbl_unit`

Operation codes:
- 0: no operation
- 1: compare the accumulator with the operand
- 2: step the index and compare it with a memory operand
- 3: step the index and compare it with a register operand
- 4: compare two registers
- 5: jump if less
- 6: jump if equal
- 7: jump if greater
- 8: call
- 9: return
- 10 to 15: no operation

## Requirements
- R1: While `rst_n` is low, and until the first valid operation, `pc_o` is 0, `cc_o` is 01 (equal), and `x_we_o` and `l_we_o` are 0.
- R2: Op 1 compares `a_i` with `opnd_i` as signed 24-bit values. It sets `cc_o` to 00 if `a_i` is the smaller, 01 if the two are equal and 10 if `a_i` is the larger. No write enable rises, and `pc_o` becomes `next_pc_i`.
- R3: Op 2 raises `x_we_o` with `x_wd_o` = `x_i`+1 modulo 2^24. It sets `cc_o` from the signed compare of that new value with `opnd_i`, using the encoding of R2, and `pc_o` becomes `next_pc_i`.
- R4: Op 3 behaves like op 2, with `opnd_i` carrying a register value instead of a memory word.
- R5: Op 4 sets `cc_o` from the signed compare of `opnd_i` with `opnd2_i`, using the encoding of R2. It writes no register.
- R6: Ops 5, 6 and 7 load `pc_o` with `target_i` when `cc_o` is 00, 01 or 10 respectively. Otherwise `pc_o` becomes `next_pc_i`.
- R7: Op 8 raises `l_we_o` with `l_wd_o` = `next_pc_i` zero-extended, and loads `pc_o` with `target_i`.
- R8: Op 9 loads `pc_o` with the low `ADDR_W` bits of `l_i`.
- R9: Ops 0 and 5 to 15 leave `cc_o` unchanged. Ops 0 and 10 to 15 set `pc_o` to `next_pc_i` and raise no write enable.
- R10: A cycle with `valid_i` low changes neither `pc_o` nor `cc_o`, and leaves both write enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 24 | Accumulator value |
| x_i | input | 24 | Index register value |
| l_i | input | 24 | Link register value |
| opnd_i | input | 24 | Memory word or first register operand |
| opnd2_i | input | 24 | Second register operand for op 4 |
| target_i | input | 20 | Jump or call target address |
| next_pc_i | input | 20 | Sequential next-PC |
| pc_o | output | 20 | Registered program counter |
| cc_o | output | 2 | Condition code state |
| x_we_o | output | 1 | Index write enable |
| x_wd_o | output | 24 | Index write data |
| l_we_o | output | 1 | Link write enable |
| l_wd_o | output | 24 | Link write data |

## Verification
The assertions assume that `rst_n` is low for at least one edge before any operation. They also assume that inputs are stable around each rising edge, and that op codes 10 to 15 may arrive at any time. The stimulus drives every input on the falling edge. It draws op codes across the whole 4-bit range, and holds `valid_i` low in about a quarter of the cycles. It often makes the two compared values equal, or picks them near the sign boundary and the wrap point of the index, so that all three condition code states and the wrap-around are reached.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_CMPA  = 4'd1;
    localparam logic [3:0] OP_IDXM  = 4'd2;
    localparam logic [3:0] OP_IDXR  = 4'd3;
    localparam logic [3:0] OP_CMPRR = 4'd4;
    localparam logic [3:0] OP_JLT   = 4'd5;
    localparam logic [3:0] OP_JEQ   = 4'd6;
    localparam logic [3:0] OP_JGT   = 4'd7;
    localparam logic [3:0] OP_CALL  = 4'd8;
    localparam logic [3:0] OP_RET   = 4'd9;

    typedef enum logic [1:0] {
        CC_LT = 2'b00,
        CC_EQ = 2'b01,
        CC_GT = 2'b10
    } cc_e;
endpackage

// File: rtl/cbl_cmp.sv
module cbl_cmp #(
    parameter int W = 24
) (
    input  logic [W-1:0]  lhs_i,
    input  logic [W-1:0]  rhs_i,
    output cbl_pkg::cc_e  res_o
);
    import cbl_pkg::*;

    always_comb begin
        if ($signed(lhs_i) < $signed(rhs_i))
            res_o = CC_LT;
        else if (lhs_i == rhs_i)
            res_o = CC_EQ;
        else
            res_o = CC_GT;
    end
endmodule

// File: rtl/cbl_idx.sv
module cbl_idx #(
    parameter int W = 24
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] x_next_o
);
    localparam logic [W-1:0] ONE = W'(1);

    assign x_next_o = x_i + ONE;
endmodule

// File: rtl/cbl_pcsel.sv
module cbl_pcsel #(
    parameter int AW = 20
) (
    input  logic [3:0]    op_i,
    input  cbl_pkg::cc_e  cc_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic [AW-1:0] ret_i,
    output logic [AW-1:0] pc_o
);
    import cbl_pkg::*;

    always_comb begin
        pc_o = next_pc_i;
        unique case (op_i)
            OP_JLT:  if (cc_i == CC_LT) pc_o = target_i;
            OP_JEQ:  if (cc_i == CC_EQ) pc_o = target_i;
            OP_JGT:  if (cc_i == CC_GT) pc_o = target_i;
            OP_CALL: pc_o = target_i;
            OP_RET:  pc_o = ret_i;
            default: pc_o = next_pc_i;
        endcase
    end
endmodule

// File: rtl/cbl_unit.sv
module cbl_unit #(
    parameter int W  = 24,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  l_i,
    input  logic [W-1:0]  opnd_i,
    input  logic [W-1:0]  opnd2_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] next_pc_i,
    output logic [AW-1:0] pc_o,
    output logic [1:0]    cc_o,
    output logic          x_we_o,
    output logic [W-1:0]  x_wd_o,
    output logic          l_we_o,
    output logic [W-1:0]  l_wd_o
);
    import cbl_pkg::*;

    localparam int PADW = W - AW;

    cc_e           cc_q, cc_d, cmp_res;
    logic [W-1:0]  x_inc, lhs, rhs;
    logic [AW-1:0] pc_nxt;
    logic          is_cmp, is_idx;

    cbl_idx #(.W(W)) u_idx (.x_i(x_i), .x_next_o(x_inc));

    cbl_cmp #(.W(W)) u_cmp (.lhs_i(lhs), .rhs_i(rhs), .res_o(cmp_res));

    cbl_pcsel #(.AW(AW)) u_pcsel (
        .op_i(op_i), .cc_i(cc_q), .target_i(target_i),
        .next_pc_i(next_pc_i), .ret_i(l_i[AW-1:0]), .pc_o(pc_nxt)
    );

    // Operand steering and condition code transitions
    always_comb begin
        lhs    = a_i;
        rhs    = opnd_i;
        is_cmp = 1'b0;
        is_idx = 1'b0;
        unique case (op_i)
            OP_CMPA:          is_cmp = 1'b1;
            OP_IDXM, OP_IDXR: begin is_cmp = 1'b1; is_idx = 1'b1; lhs = x_inc; end
            OP_CMPRR:         begin is_cmp = 1'b1; lhs = opnd_i; rhs = opnd2_i; end
            default:          is_cmp = 1'b0;
        endcase
        cc_d = cc_q;
        if (valid_i && is_cmp) begin
            unique case (cc_q)
                CC_LT, CC_EQ, CC_GT: cc_d = cmp_res;
                default:             cc_d = CC_EQ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) cc_q <= CC_EQ;
        else        cc_q <= cc_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o   <= '0;
            x_we_o <= 1'b0;
            x_wd_o <= '0;
            l_we_o <= 1'b0;
            l_wd_o <= '0;
        end else begin
            x_we_o <= valid_i && is_idx;
            l_we_o <= valid_i && (op_i == OP_CALL);
            if (valid_i) begin
                pc_o   <= pc_nxt;
                x_wd_o <= x_inc;
                l_wd_o <= {{PADW{1'b0}}, next_pc_i};
            end
        end
    end

    assign cc_o = cc_q;

    AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cc_o != 2'b11); // R2
    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (op_i == OP_IDXM || op_i == OP_IDXR) |=> x_we_o && x_wd_o == $past(x_i) + W'(1)); // R3
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == OP_CALL |=> l_we_o && pc_o == $past(target_i)); // R7
    AST_RET_PC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == OP_RET |=> pc_o == $past(l_i[AW-1:0])); // R8
    AST_CC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i > OP_CMPRR |=> $stable(cc_o)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pc_o) && $stable(cc_o) && !x_we_o && !l_we_o); // R10
    AST_JEQ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == OP_JEQ && cc_o != 2'b01 |=> pc_o == $past(next_pc_i)); // R6
endmodule

// File: tb/cbl_unit_test.sv
module cbl_unit_test;
    localparam int W  = 24;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic [W-1:0]  a_i = '0, x_i = '0, l_i = '0, opnd_i = '0, opnd2_i = '0;
    logic [AW-1:0] target_i = '0, next_pc_i = '0;
    logic [AW-1:0] pc_o;
    logic [1:0]    cc_o;
    logic          x_we_o, l_we_o;
    logic [W-1:0]  x_wd_o, l_wd_o;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] e_pc = '0;
    logic [1:0]    e_cc = 2'b01;

    always #2.5 clk = ~clk;

    cbl_unit #(.W(W), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .x_i(x_i), .l_i(l_i), .opnd_i(opnd_i), .opnd2_i(opnd2_i),
        .target_i(target_i), .next_pc_i(next_pc_i), .pc_o(pc_o), .cc_o(cc_o),
        .x_we_o(x_we_o), .x_wd_o(x_wd_o), .l_we_o(l_we_o), .l_wd_o(l_wd_o)
    );

    function automatic logic [1:0] cmp_model(logic [W-1:0] p, logic [W-1:0] q);
        if ($signed(p) < $signed(q)) return 2'b00;
        if (p == q) return 2'b01;
        return 2'b10;
    endfunction

    function automatic string tag_of(logic v, logic [3:0] op);
        if (!v) return "R10";
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5, 4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(logic v, logic [3:0] op, logic [W-1:0] a, logic [W-1:0] x,
                          logic [W-1:0] l, logic [W-1:0] o1, logic [W-1:0] o2,
                          logic [AW-1:0] tg, logic [AW-1:0] np);
        string tag;
        logic exp_xwe, exp_lwe;
        logic [W-1:0] x_next;
        x_next = x + W'(1);
        valid_i = v; op_i = op; a_i = a; x_i = x; l_i = l;
        opnd_i = o1; opnd2_i = o2; target_i = tg; next_pc_i = np;
        tag = tag_of(v, op);
        exp_xwe = v && (op == 4'd2 || op == 4'd3);
        exp_lwe = v && op == 4'd8;
        if (v) begin
            logic [1:0] old_cc;
            old_cc = e_cc;
            case (op)
                4'd1: e_cc = cmp_model(a, o1);
                4'd2, 4'd3: e_cc = cmp_model(x_next, o1);
                4'd4: e_cc = cmp_model(o1, o2);
                default: e_cc = e_cc;
            endcase
            case (op)
                4'd5: e_pc = (old_cc == 2'b00) ? tg : np;
                4'd6: e_pc = (old_cc == 2'b01) ? tg : np;
                4'd7: e_pc = (old_cc == 2'b10) ? tg : np;
                4'd8: e_pc = tg;
                4'd9: e_pc = l[AW-1:0];
                default: e_pc = np;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pc", 32'(pc_o), 32'(e_pc));
        chk(tag, "cc", 32'(cc_o), 32'(e_cc));
        chk(tag, "x_we", 32'(x_we_o), 32'(exp_xwe));
        chk(tag, "l_we", 32'(l_we_o), 32'(exp_lwe));
        if (exp_xwe) chk(tag, "x_wd", 32'(x_wd_o), 32'(x_next));
        if (exp_lwe) chk(tag, "l_wd", 32'(l_wd_o), 32'(np));
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1", "pc", 32'(pc_o), 0);
        chk("R1", "cc", 32'(cc_o), 1);
        chk("R1", "x_we", 32'(x_we_o), 0);
        chk("R1", "l_we", 32'(l_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pc after release", 32'(pc_o), 0);

        // directed corners
        run_op(1, 4'd1, 24'h800000, 0, 0, 24'h000001, 0, 20'h1, 20'h3);  // R2 negative below positive
        run_op(1, 4'd5, 0, 0, 0, 0, 0, 20'h100, 20'h6);                  // R6 taken
        run_op(1, 4'd1, 24'h000123, 0, 0, 24'h000123, 0, 0, 20'h9);      // R2 equal
        run_op(0, 4'd1, 24'h7FFFFF, 0, 0, 24'h800000, 0, 0, 20'hAA);     // R10
        run_op(1, 4'd7, 0, 0, 0, 0, 0, 20'h200, 20'hC);                  // R6 not taken
        run_op(1, 4'd2, 0, 24'hFFFFFF, 0, 24'h000000, 0, 0, 20'hF);      // R3 wrap to zero, equal
        run_op(1, 4'd3, 0, 24'h000004, 0, 24'h000002, 0, 0, 20'h12);     // R4 greater
        run_op(1, 4'd4, 0, 0, 0, 24'hFFFFFE, 24'h000001, 0, 20'h15);     // R5 less
        run_op(1, 4'd8, 0, 0, 0, 0, 0, 20'hABCDE, 20'h18);               // R7 call
        run_op(1, 4'd9, 0, 0, 24'hF12345, 0, 0, 0, 20'h1B);              // R8 return
        run_op(1, 4'd12, 0, 0, 0, 0, 0, 20'h77, 20'h1E);                 // R9 unused code

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, x, o1, o2;
            logic [3:0] op;
            a  = $urandom; x = $urandom; o1 = $urandom; o2 = $urandom;
            op = 4'($urandom_range(0, 15));
            case ($urandom_range(0, 3))
                0: begin o1 = a; o2 = o1; end
                1: o1 = x + W'(1);
                2: begin x = 24'hFFFFFF; o1 = $urandom_range(0, 1); end
                default: ;
            endcase
            run_op(($urandom_range(0, 3) != 0), op, a, x, 24'($urandom), o1, o2,
                   20'($urandom), 20'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule